// File: doc/BRIEF.md
# Integer Add-Immediate Execution Unit

This unit is the integer add stage of a 32-bit datapath. Each transaction brings two source register values, a 4-bit operation code and the raw immediate fields of the instruction: an 8-bit immediate and a 4-bit narrow field. The fields arrive already extracted by the decoder. The unit builds the second operand from whichever field the operation uses and performs one of these: an add, an add with an operand scaled by a shift, a bitwise AND, or an absolute value. It returns a 32-bit result and a write-enable flag that marks the result as one to commit to the register file.

All arithmetic wraps modulo 2^32, and no overflow indication exists anywhere. The input and output are valid/ready streams, and the output stage is one register deep. A transaction is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented from the next cycle with `out_valid` high. The result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result, the write enable and `out_valid` itself hold still, and `in_ready` is low. A held result never blocks a new one once `out_ready` rises: in that cycle `in_ready` is high, so one result can be consumed and the next accepted on the same edge.

Top module: `exu_addimm_unit`

## Requirements
- R1: Code 0 returns `in_src_a + in_src_b`, keeps only the low 32 bits of the sum (0xFFFFFFFF + 2 gives 1), and sets the write enable.
- R2: Code 1 adds `in_imm` to `in_src_a` after sign-extending the immediate, so 0x80 adds -128 and 0x7F adds 127.
- R3: Code 2 adds the narrow field to `in_src_a`. A field value of 0 adds -1, and any other value 1..15 is zero-extended and added.
- R4: Code 3 sign-extends `in_imm` and multiplies it by 256 before adding it to `in_src_a`, so 0x80 adds -32768 and 0x7F adds 32512.
- R5: Codes 4, 5 and 6 return `(in_src_a << k) + in_src_b` with k equal to 1, 2 and 3 respectively, and discard the bits shifted out at the top.
- R6: Code 7 returns the bitwise AND of `in_src_a` and `in_src_b` and sets the write enable.
- R7: Code 8 returns the two's complement negation of `in_src_a` when its bit 31 is set, and `in_src_a` unchanged otherwise. 0x80000000 therefore returns 0x80000000.
- R8: Codes 9 to 15 complete as transactions, but the result is 0 and the write enable is low.
- R9: A transaction accepted on one rising edge raises `out_valid` with its result after that edge. If nothing new is accepted on the edge that consumes it, `out_valid` falls.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_result` and `out_we` stay unchanged. When `out_ready` rises, a pending input is accepted on the same edge that consumes the held result.
- R11: Synchronous active-high `rst` clears `out_valid`, `out_result` and `out_we` on the next rising edge, even when a result is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_op | input | 4 | Operation code (0..8 defined) |
| in_src_a | input | 32 | First source register value |
| in_src_b | input | 32 | Second source register value |
| in_imm | input | 8 | Raw 8-bit immediate field |
| in_nib | input | 4 | Raw 4-bit narrow immediate field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Computed result |
| out_we | output | 1 | Result is to be written back |

## Verification
The assertions check the handshake on every cycle: acceptance leads to a valid output, a stalled output stays frozen and blocks the input, and an idle consume drops `out_valid`. They also check per-operation properties that hold for any operand: the narrow field of zero subtracts one, absolute value is non-negative for every input except the most negative one, the AND result is a subset of the first operand, and unused codes never write. The exact sum for each decoding of the immediates can be shown only by the bench's scenarios, which compare against an independent model. These include the immediate extremes, the scaled adds dropping high bits, 0x80000000 into absolute value, and reset during a stall.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int OP_W      = 4;
  localparam int SCALE_MAX = 3;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_ADDI = 4'd1;
  localparam logic [OP_W-1:0] OP_ADDN = 4'd2;
  localparam logic [OP_W-1:0] OP_ADDM = 4'd3;
  localparam logic [OP_W-1:0] OP_SX1  = 4'd4;
  localparam logic [OP_W-1:0] OP_SX2  = 4'd5;
  localparam logic [OP_W-1:0] OP_SX3  = 4'd6;
  localparam logic [OP_W-1:0] OP_AND  = 4'd7;
  localparam logic [OP_W-1:0] OP_ABS  = 4'd8;

  typedef enum logic [1:0] {
    FN_NONE = 2'd0,
    FN_ADD  = 2'd1,
    FN_AND  = 2'd2,
    FN_ABS  = 2'd3
  } exu_fn_e;

endpackage

// File: rtl/exu_operand_gen.sv
module exu_operand_gen
  import exu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int NIB_W     = 4,
  parameter int MID_SHIFT = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [NIB_W-1:0]  nib,
  output logic [DATA_W-1:0] lhs,
  output logic [DATA_W-1:0] rhs,
  output exu_fn_e           fn
);

  localparam int IMM_PAD = DATA_W - IMM_W;
  localparam int NIB_PAD = DATA_W - NIB_W;

  // Left operand scaled by 0..SCALE_MAX; top bits fall off.
  logic [DATA_W-1:0] scaled [0:SCALE_MAX];

  genvar g;
  generate
    for (g = 0; g <= SCALE_MAX; g++) begin : g_scale
      assign scaled[g] = src_a << g;
    end
  endgenerate

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] imm_mid;
  logic [DATA_W-1:0] nib_val;

  assign imm_sx  = {{IMM_PAD{imm[IMM_W-1]}}, imm};
  assign imm_mid = imm_sx << MID_SHIFT;
  // A zero narrow field stands for minus one.
  assign nib_val = (nib == '0) ? {DATA_W{1'b1}} : {{NIB_PAD{1'b0}}, nib};

  always_comb begin
    lhs = scaled[0];
    rhs = src_b;
    fn  = FN_ADD;
    unique case (op)
      OP_ADD:  rhs = src_b;
      OP_ADDI: rhs = imm_sx;
      OP_ADDN: rhs = nib_val;
      OP_ADDM: rhs = imm_mid;
      OP_SX1:  lhs = scaled[1];
      OP_SX2:  lhs = scaled[2];
      OP_SX3:  lhs = scaled[3];
      OP_AND:  fn  = FN_AND;
      OP_ABS:  fn  = FN_ABS;
      default: begin
        fn  = FN_NONE;
        lhs = '0;
        rhs = '0;
      end
    endcase
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  exu_fn_e           fn,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] result,
  output logic              we
);

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] conj;
  logic [DATA_W-1:0] mag;

  assign sum  = lhs + rhs;
  assign conj = lhs & rhs;
  // Negation wraps, so the most negative value maps to itself.
  assign mag  = lhs[DATA_W-1] ? (~lhs + DATA_W'(1)) : lhs;

  always_comb begin
    result = '0;
    we     = 1'b1;
    unique case (fn)
      FN_ADD:  result = sum;
      FN_AND:  result = conj;
      FN_ABS:  result = mag;
      default: begin
        result = '0;
        we     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/exu_out_stage.sv
module exu_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  output logic              d_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_we,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_result,
  output logic              q_we
);

  assign d_ready = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_we     <= 1'b0;
    end else if (d_ready) begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_result <= d_result;
        q_we     <= d_we;
      end
    end
  end

endmodule

// File: rtl/exu_addimm_unit.sv
module exu_addimm_unit
  import exu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int NIB_W     = 4,
  parameter int MID_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_src_a,
  input  logic [DATA_W-1:0] in_src_b,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [NIB_W-1:0]  in_nib,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_we
);

  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;
  exu_fn_e           fn;
  logic [DATA_W-1:0] alu_res;
  logic              alu_we;

  exu_operand_gen #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .NIB_W(NIB_W), .MID_SHIFT(MID_SHIFT)
  ) opgen_i (
    .op(in_op), .src_a(in_src_a), .src_b(in_src_b),
    .imm(in_imm), .nib(in_nib),
    .lhs(lhs), .rhs(rhs), .fn(fn)
  );

  exu_alu #(.DATA_W(DATA_W)) alu_i (
    .fn(fn), .lhs(lhs), .rhs(rhs), .result(alu_res), .we(alu_we)
  );

  exu_out_stage #(.DATA_W(DATA_W)) stage_i (
    .clk(clk), .rst(rst),
    .d_valid(in_valid), .d_ready(in_ready),
    .d_result(alu_res), .d_we(alu_we),
    .q_valid(out_valid), .q_ready(out_ready),
    .q_result(out_result), .q_we(out_we)
  );

endmodule

// File: rtl/exu_addimm_unit_chk.sv
module exu_addimm_unit_chk
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic [DATA_W-1:0] in_src_a,
  input logic [DATA_W-1:0] in_src_b,
  input logic [IMM_W-1:0]  in_imm,
  input logic [NIB_W-1:0]  in_nib,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_we
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic take;
  assign take = in_valid && in_ready;

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid); // R9

  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_we)); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R10

  AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (rst)
    take && (in_op > OP_ABS) |=> !out_we && (out_result == '0)); // R8

  AST_NARROW_MINUS1: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_ADDN) && (in_nib == '0)
    |=> out_result == $past(in_src_a) - DATA_W'(1)); // R3

  AST_ABS_SIGN: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_ABS) && (in_src_a != MOST_NEG)
    |=> out_we && !out_result[DATA_W-1]); // R7

  AST_AND_SUBSET: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_AND) |=> (out_result & ~$past(in_src_a)) == '0); // R6

  logic unused_ok;
  assign unused_ok = ^{in_src_b, in_imm};

endmodule

bind exu_addimm_unit exu_addimm_unit_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .NIB_W(NIB_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
  .in_imm(in_imm), .in_nib(in_nib), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_we(out_we)
);

// File: tb/exu_addimm_unit_tb_top.sv
`timescale 1ns/1ps
module exu_addimm_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_src_a = '0;
  logic [31:0] in_src_b = '0;
  logic [7:0]  in_imm = '0;
  logic [3:0]  in_nib = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_we;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;

  exu_addimm_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_imm(in_imm), .in_nib(in_nib), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_we(out_we)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent model: returns {we, result}.
  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [7:0] im,
                                        input logic [3:0] nb);
    logic [63:0] wide;
    case (op)
      4'd0: model = {1'b1, a + b};
      4'd1: model = {1'b1, a + 32'($signed(im))};
      4'd2: model = {1'b1, (nb == 4'd0) ? a - 32'd1 : a + {28'd0, nb}};
      4'd3: model = {1'b1, a + 32'($signed(im)) * 32'd256};
      4'd4, 4'd5, 4'd6: begin
        wide  = {32'd0, a} * (64'd1 << (op - 4'd3));
        model = {1'b1, wide[31:0] + b};
      end
      4'd7: model = {1'b1, a & b};
      4'd8: model = {1'b1, a[31] ? 32'd0 - a : a};
      default: model = 33'd0;
    endcase
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0: op_tag = "R1";
      4'd1: op_tag = "R2";
      4'd2: op_tag = "R3";
      4'd3: op_tag = "R4";
      4'd4, 4'd5, 4'd6: op_tag = "R5";
      4'd7: op_tag = "R6";
      4'd8: op_tag = "R7";
      default: op_tag = "R8";
    endcase
  endfunction

  // One accepted transaction, result checked the cycle after acceptance.
  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [7:0] im, input logic [3:0] nb);
    logic [32:0] exp;
    string tag;
    exp = model(op, a, b, im, nb);
    tag = op_tag(op);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_op = op; in_src_a = a; in_src_b = b; in_imm = im; in_nib = nb;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "out_valid after accept", {31'd0, out_valid}, 32'd1);
    chk(tag, "result", out_result, exp[31:0]);
    chk(tag, "write enable", {31'd0, out_we}, {31'd0, exp[32]});
  endtask

  task automatic t_reset;
    chk("R11", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R11", "out_result in reset", out_result, 32'd0);
    chk("R11", "out_we in reset", {31'd0, out_we}, 32'd0);
  endtask

  task automatic t_add;
    run_op(4'd0, 32'd100, 32'd23, 8'h00, 4'h0);
    run_op(4'd0, 32'hFFFF_FFFF, 32'd2, 8'h00, 4'h0);      // R1 wrap gives 1
    chk("R1", "wrap literal", out_result, 32'd1);
  endtask

  task automatic t_addi;
    run_op(4'd1, 32'd1000, 32'hDEAD_BEEF, 8'h80, 4'h0);   // R2 -128
    chk("R2", "imm 0x80", out_result, 32'd872);
    run_op(4'd1, 32'd1000, 32'd0, 8'h7F, 4'h0);           // R2 +127
    chk("R2", "imm 0x7F", out_result, 32'd1127);
  endtask

  task automatic t_narrow;
    run_op(4'd2, 32'd50, 32'd999, 8'hFF, 4'h0);           // R3 zero field subtracts one
    chk("R3", "nib 0", out_result, 32'd49);
    run_op(4'd2, 32'd0, 32'd0, 8'h00, 4'h0);
    chk("R3", "nib 0 from zero", out_result, 32'hFFFF_FFFF);
    run_op(4'd2, 32'd50, 32'd0, 8'h00, 4'hF);
    chk("R3", "nib 15", out_result, 32'd65);
    run_op(4'd2, 32'd50, 32'd0, 8'h00, 4'h1);
  endtask

  task automatic t_mid;
    run_op(4'd3, 32'd0, 32'd0, 8'h80, 4'h0);              // R4 -32768
    chk("R4", "imm 0x80 scaled", out_result, 32'hFFFF_8000);
    run_op(4'd3, 32'd0, 32'd0, 8'h7F, 4'h0);              // R4 +32512
    chk("R4", "imm 0x7F scaled", out_result, 32'd32512);
  endtask

  task automatic t_scaled;
    run_op(4'd4, 32'hC000_0001, 32'd5, 8'h00, 4'h0);
    chk("R5", "shift 1", out_result, 32'h8000_0007);
    run_op(4'd5, 32'hC000_0001, 32'd5, 8'h00, 4'h0);
    chk("R5", "shift 2 drops top", out_result, 32'd9);
    run_op(4'd6, 32'hC000_0001, 32'd5, 8'h00, 4'h0);
    chk("R5", "shift 3 drops top", out_result, 32'd13);
  endtask

  task automatic t_and;
    run_op(4'd7, 32'hF0F0_1234, 32'h0FF0_FF00, 8'h00, 4'h0);
    chk("R6", "and", out_result, 32'h00F0_1200);
  endtask

  task automatic t_abs;
    run_op(4'd8, 32'hFFFF_FFFB, 32'd0, 8'h00, 4'h0);
    chk("R7", "abs -5", out_result, 32'd5);
    run_op(4'd8, 32'd7, 32'd0, 8'h00, 4'h0);
    chk("R7", "abs 7", out_result, 32'd7);
    run_op(4'd8, 32'h8000_0000, 32'd0, 8'h00, 4'h0);
    chk("R7", "abs most negative", out_result, 32'h8000_0000);
  endtask

  task automatic t_unused;
    for (int k = 9; k < 16; k++) begin
      run_op(4'(k), 32'h1234_5678, 32'h9ABC_DEF0, 8'hAA, 4'h5);
      chk("R8", "unused result", out_result, 32'd0);
      chk("R8", "unused we", {31'd0, out_we}, 32'd0);
    end
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      run_op(4'($urandom_range(0, 15)), $urandom, $urandom,
             8'($urandom), 4'($urandom));
    end
  endtask

  task automatic t_idle;
    run_op(4'd0, 32'd1, 32'd1, 8'h00, 4'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "out_valid after idle consume", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    in_op = 4'd0; in_src_a = 32'd1; in_src_b = 32'd2;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "first result", out_result, 32'd3);
    chk("R10", "in_ready low while stalled", {31'd0, in_ready}, 32'd0);
    in_src_a = 32'd10; in_src_b = 32'd20;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10", "held result", out_result, 32'd3);
      chk("R10", "held valid", {31'd0, out_valid}, 32'd1);
      chk("R10", "in_ready held low", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "pending accepted on consume", out_result, 32'd30);
    chk("R10", "valid after swap", {31'd0, out_valid}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset_stall;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    in_op = 4'd7; in_src_a = 32'hFFFF_FFFF; in_src_b = 32'h5555_5555;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    chk("R11", "valid cleared in stall", {31'd0, out_valid}, 32'd0);
    chk("R11", "result cleared in stall", out_result, 32'd0);
    chk("R11", "we cleared in stall", {31'd0, out_we}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_add();
    t_addi();
    t_narrow();
    t_mid();
    t_scaled();
    t_and();
    t_abs();
    t_unused();
    t_idle();
    t_backpressure();
    t_random();
    t_reset_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule